// File: doc/BRIEF.md
# Walking-Bit Memory Pattern Tester

This block exercises a 72-bit-wide synchronous RAM with a fixed schedule of 144 base patterns. The first 72 patterns carry a single set bit and the next 72 carry a single cleared bit. For each pattern the block runs a write pass over a chosen inclusive address range. The first address in the range gets the base pattern, and every later address gets the word of the address before it rotated left by one bit across all 72 bits. The block then reads the same addresses back in the same order and compares each word against the value it expects. Each 36-bit half is filtered by its own compare mask.

Software or a test sequencer sets the range, the address increment, the two masks and two trigger addresses, then pulses `start`. The block keeps `busy` high while it runs. It ends with `done` high, and `fail` is also high if a miscompare was found. The first miscompare stops the run and holds the failing address, the failing halves, the expected word and the word actually read. A one-cycle trigger strobe fires in the cycle before the write to one chosen address, and another fires in the cycle before the read of a second chosen address, so an external probe can be armed at that point.

The RAM side is a plain synchronous port. Write and read strobes are never high together, and read data returns one cycle after the read strobe. The port has no valid/ready handshake and no back-pressure: the RAM must accept one access on every cycle that a strobe is high. All control and status pins are level signals.

Top module: `walkpat_tester`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `ram_we`, `ram_re`, `wtrig` and `rtrig` are all 0.
- R2: A `start` pulse seen while the block is idle or done captures every `cfg_*` input and begins a run on the next cycle. A `start` pulse seen while `busy` is high is ignored, and the run in progress is unchanged.
- R3: For each pattern the block spends one setup cycle, then one write cycle per address in ascending order, then one setup cycle, then one read cycle per address in the same order, then one trailing cycle. `ram_we` and `ram_re` are never high together.
- R4: Within a write pass, each address after the first receives the previous address's data rotated left by one, with bit 71 moving into bit 0.
- R5: Pattern k, for k from 0 to 71, has only bit k set. Pattern 72+k has only bit k cleared. The 144 patterns run in that order, and each one is written first at the low address.
- R6: The address sequence is low, low+step, low+2·step and so on, and it stops at the last value not above the high address. It never wraps. A step of 0 acts as a step of 1.
- R7: If the low address is above the high address, `done` rises on the cycle after `start`, with no RAM access and `fail` at 0.
- R8: Read data is taken from `ram_rdata` one cycle after the matching read strobe, and `fail_act` holds that raw word.
- R9: Bits [71:36] are compared only where `cfg_mask_hi` has a 1, and bits [35:0] only where `cfg_mask_lo` has a 1. A difference at a masked-off bit does not cause a failure.
- R10: On the first miscompare, `fail` and `done` go high in the cycle after the comparison. At that point `fail_addr`, `fail_exp` and `fail_act` are held, `fail_half` bit 1 flags the upper half and bit 0 flags the lower half, and no further RAM access is made.
- R11: `wtrig` is high for exactly the cycle before each write to `cfg_wtrig_addr`.
- R12: `rtrig` is high for exactly the cycle before each read of `cfg_rtrig_addr`.
- R13: `busy` is high from the cycle after an accepted `start` until the run ends. `done` is then held high, with `busy` low, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when idle or done) |
| cfg_lo | input | AW | First address of the range |
| cfg_hi | input | AW | Last address allowed in the range |
| cfg_step | input | AW | Address increment (0 means 1) |
| cfg_mask_hi | input | DW/2 | Compare mask for bits [71:36] |
| cfg_mask_lo | input | DW/2 | Compare mask for bits [35:0] |
| cfg_wtrig_addr | input | AW | Address whose write is preceded by `wtrig` |
| cfg_rtrig_addr | input | AW | Address whose read is preceded by `rtrig` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| fail | output | 1 | A miscompare stopped the run |
| fail_addr | output | AW | Address of the first miscompare |
| fail_half | output | 2 | Failing halves: bit 1 upper, bit 0 lower |
| fail_exp | output | DW | Expected word at the failure |
| fail_act | output | DW | Word read at the failure |
| wtrig | output | 1 | Strobe one cycle ahead of the chosen write |
| rtrig | output | 1 | Strobe one cycle ahead of the chosen read |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after `ram_re` |

## Verification
The bench targets these corner cases:

- **Hand-over to the inverted pattern set.** After pattern 71 the base must become all ones with bit 0 cleared. A design that simply kept rotating the base would repeat the single-one patterns and write wrong data throughout the second half of the schedule.
- **Range ending at the top of the address space, and steps that overshoot the high address.** A design that lost the carry would wrap back to address 0 and write outside the range. One that checked equality instead of "greater than" would never stop.
- **Triggers on the first and last addresses.** The first-address trigger has to come from the setup cycle. A design that drew the strobe only from the running address would miss it, or would fire it after the access.
- **Stuck bits, masked and unmasked, in each half.** If the one-cycle read latency were ignored, the block would compare against the wrong address's word. If the mask were applied to the wrong half, the block would either report a masked-off fault or let a real one pass.

// File: rtl/walkpat_pkg.sv
package walkpat_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSET,
    S_WR,
    S_RSET,
    S_RD,
    S_RTAIL,
    S_DONE
  } wp_state_e;

endpackage

// File: rtl/wp_addr_seq.sv
module wp_addr_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] next_addr,
  output logic          last
);

  // one extra bit so the top of the address space never wraps
  logic [AW:0] sum;

  assign sum       = {1'b0, addr} + {1'b0, step};
  assign next_addr = sum[AW-1:0];
  assign last      = sum > {1'b0, hi};

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base_addr;
    else if (adv)  addr <= next_addr;
  end

endmodule

// File: rtl/wp_pattern.sv
module wp_pattern #(
  parameter int DW = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          rewind,
  input  logic          adv,
  input  logic          next_pat,
  output logic [DW-1:0] dat,
  output logic          last_pat
);

  localparam int NPAT = 2 * DW;
  localparam int PW   = $clog2(NPAT);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] base;
  logic [DW-1:0] nbase;
  logic [PW-1:0] pidx;

  function automatic logic [DW-1:0] rotl1(input logic [DW-1:0] v);
    return {v[DW-2:0], v[DW-1]};
  endfunction

  // after the single-one set, switch to the single-zero set
  assign nbase    = (pidx == PW'(DW - 1)) ? ~ONE : rotl1(base);
  assign last_pat = (pidx == PW'(NPAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= ONE;
      dat  <= ONE;
      pidx <= '0;
    end else if (init) begin
      base <= ONE;
      dat  <= ONE;
      pidx <= '0;
    end else if (next_pat) begin
      base <= nbase;
      dat  <= nbase;
      pidx <= pidx + 1'b1;
    end else if (rewind) begin
      dat <= base;
    end else if (adv) begin
      dat <= rotl1(dat);
    end
  end

endmodule

// File: rtl/wp_compare.sv
module wp_compare #(
  parameter int AW = 8,
  parameter int DW = 72
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            issue,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   exp_dat,
  input  logic [DW-1:0]   rdata,
  input  logic [DW/2-1:0] mask_hi,
  input  logic [DW/2-1:0] mask_lo,
  output logic            miss,
  output logic            fail,
  output logic [AW-1:0]   fail_addr,
  output logic [1:0]      fail_half,
  output logic [DW-1:0]   fail_exp,
  output logic [DW-1:0]   fail_act
);

  localparam int HW = DW / 2;

  logic          v_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] mask;
  logic [1:0]    hmiss;

  assign mask = {mask_hi, mask_lo};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign hmiss[h] = |((exp_q[h*HW +: HW] ^ rdata[h*HW +: HW]) & mask[h*HW +: HW]);
  end

  assign miss = v_q && (|hmiss) && !fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= 1'b0;
      addr_q    <= '0;
      exp_q     <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_half <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else begin
      v_q <= issue;
      if (issue) begin
        addr_q <= addr;
        exp_q  <= exp_dat;
      end
      if (clr) begin
        fail      <= 1'b0;
        fail_addr <= '0;
        fail_half <= '0;
        fail_exp  <= '0;
        fail_act  <= '0;
      end else if (miss) begin
        fail      <= 1'b1;
        fail_addr <= addr_q;
        fail_half <= hmiss;
        fail_exp  <= exp_q;
        fail_act  <= rdata;
      end
    end
  end

endmodule

// File: rtl/walkpat_tester.sv
module walkpat_tester
  import walkpat_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 72
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   cfg_lo,
  input  logic [AW-1:0]   cfg_hi,
  input  logic [AW-1:0]   cfg_step,
  input  logic [DW/2-1:0] cfg_mask_hi,
  input  logic [DW/2-1:0] cfg_mask_lo,
  input  logic [AW-1:0]   cfg_wtrig_addr,
  input  logic [AW-1:0]   cfg_rtrig_addr,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [AW-1:0]   fail_addr,
  output logic [1:0]      fail_half,
  output logic [DW-1:0]   fail_exp,
  output logic [DW-1:0]   fail_act,
  output logic            wtrig,
  output logic            rtrig,
  output logic            ram_we,
  output logic            ram_re,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  input  logic [DW-1:0]   ram_rdata
);

  localparam int HW = DW / 2;

  wp_state_e st;

  logic [AW-1:0] lo_q, hi_q, step_q, wta_q, rta_q;
  logic [HW-1:0] mhi_q, mlo_q;

  logic          accept, at_rest;
  logic          ag_load, ag_adv, last;
  logic [AW-1:0] addr, next_addr, base_addr;
  logic          pg_rewind, pg_next, last_pat;
  logic [DW-1:0] dat;
  logic          miss;

  assign at_rest   = (st == S_IDLE) || (st == S_DONE);
  assign accept    = start && at_rest;
  assign base_addr = at_rest ? cfg_lo : lo_q;

  assign pg_rewind = (st == S_WR) && last;
  assign pg_next   = (st == S_RTAIL) && !miss && !last_pat;
  assign ag_load   = accept || pg_rewind || pg_next;
  assign ag_adv    = ((st == S_WR) && !last) || ((st == S_RD) && !last && !miss);

  wp_addr_seq #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ag_load),
    .adv       (ag_adv),
    .base_addr (base_addr),
    .hi        (hi_q),
    .step      (step_q),
    .addr      (addr),
    .next_addr (next_addr),
    .last      (last)
  );

  wp_pattern #(.DW(DW)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (accept),
    .rewind   (pg_rewind),
    .adv      (ag_adv),
    .next_pat (pg_next),
    .dat      (dat),
    .last_pat (last_pat)
  );

  wp_compare #(.AW(AW), .DW(DW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .issue     (st == S_RD),
    .addr      (addr),
    .exp_dat   (dat),
    .rdata     (ram_rdata),
    .mask_hi   (mhi_q),
    .mask_lo   (mlo_q),
    .miss      (miss),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_half (fail_half),
    .fail_exp  (fail_exp),
    .fail_act  (fail_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lo_q   <= '0;
      hi_q   <= '0;
      step_q <= AW'(1);
      wta_q  <= '0;
      rta_q  <= '0;
      mhi_q  <= '0;
      mlo_q  <= '0;
    end else begin
      if (accept) begin
        lo_q   <= cfg_lo;
        hi_q   <= cfg_hi;
        step_q <= (cfg_step == '0) ? AW'(1) : cfg_step;
        wta_q  <= cfg_wtrig_addr;
        rta_q  <= cfg_rtrig_addr;
        mhi_q  <= cfg_mask_hi;
        mlo_q  <= cfg_mask_lo;
      end
      unique case (st)
        S_IDLE, S_DONE: if (accept) st <= (cfg_lo > cfg_hi) ? S_DONE : S_WSET;
        S_WSET:         st <= S_WR;
        S_WR:           if (last) st <= S_RSET;
        S_RSET:         st <= S_RD;
        S_RD:           if (miss) st <= S_DONE; else if (last) st <= S_RTAIL;
        S_RTAIL:        st <= (miss || last_pat) ? S_DONE : S_WSET;
        default:        st <= S_IDLE;
      endcase
    end
  end

  assign busy      = !at_rest;
  assign done      = (st == S_DONE);
  assign ram_we    = (st == S_WR);
  assign ram_re    = (st == S_RD);
  assign ram_addr  = addr;
  assign ram_wdata = dat;

  assign wtrig = ((st == S_WSET) && (addr == wta_q)) ||
                 ((st == S_WR) && !last && (next_addr == wta_q));
  assign rtrig = ((st == S_RSET) && (addr == rta_q)) ||
                 ((st == S_RD) && !last && (next_addr == rta_q));

endmodule

// File: rtl/walkpat_tester_chk.sv
module walkpat_tester_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_we,
  input logic          ram_re,
  input logic [AW-1:0] ram_addr,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [1:0]    fail_half,
  input logic          wtrig,
  input logic          rtrig,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q,
  input logic [AW-1:0] wta_q,
  input logic [AW-1:0] rta_q
);

  // R3
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  // R3
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> (ram_addr > $past(ram_addr)));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> ((ram_addr >= lo_q) && (ram_addr <= hi_q)));

  // R11
  wtrig_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wtrig |=> (ram_we && (ram_addr == wta_q)));

  // R12
  rtrig_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtrig |=> ((ram_re && (ram_addr == rta_q)) || fail));

  // R10
  fail_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (done && (fail_half != 2'b00)));

  // R10
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !(ram_we || ram_re));

  // R13
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

bind walkpat_tester walkpat_tester_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ram_we    (ram_we),
  .ram_re    (ram_re),
  .ram_addr  (ram_addr),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_half (fail_half),
  .wtrig     (wtrig),
  .rtrig     (rtrig),
  .lo_q      (lo_q),
  .hi_q      (hi_q),
  .wta_q     (wta_q),
  .rta_q     (rta_q)
);

// File: tb/walkpat_tester_bench.sv
`timescale 1ns/1ps
module walkpat_tester_bench;

  localparam int AW = 8;
  localparam int DW = 72;
  localparam int HW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0, cfg_step = '0;
  logic [HW-1:0] cfg_mask_hi = '1, cfg_mask_lo = '1;
  logic [AW-1:0] cfg_wtrig_addr = '0, cfg_rtrig_addr = '0;
  logic          busy, done, fail, wtrig, rtrig, ram_we, ram_re;
  logic [AW-1:0] fail_addr, ram_addr;
  logic [1:0]    fail_half;
  logic [DW-1:0] fail_exp, fail_act, ram_wdata;
  logic [DW-1:0] ram_rdata = '0;

  int total = 0;
  int bad = 0;
  int ccount = 0;
  int poke_at = -1;
  string cur_tag = "";

  int   stuck_en = 0, stuck_addr = 0, stuck_bit = 0;
  logic stuck_val = 1'b0;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  always #2.5 clk = ~clk;

  walkpat_tester u_walkpat_tester (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_step(cfg_step),
    .cfg_mask_hi(cfg_mask_hi), .cfg_mask_lo(cfg_mask_lo),
    .cfg_wtrig_addr(cfg_wtrig_addr), .cfg_rtrig_addr(cfg_rtrig_addr),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_half(fail_half), .fail_exp(fail_exp), .fail_act(fail_act),
    .wtrig(wtrig), .rtrig(rtrig), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [DW-1:0] fault(input int a, input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    if (stuck_en != 0 && a == stuck_addr) r[stuck_bit] = stuck_val;
    return r;
  endfunction

  function automatic logic [DW-1:0] rotl(input logic [DW-1:0] v);
    return {v[DW-2:0], v[DW-1]};
  endfunction

  // behavioural RAM with optional stuck bit on reads
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= fault(int'(ram_addr), mem[ram_addr]);
  end

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // one model cycle: compare all outputs, then advance to the next sample point
  task automatic cyc(input bit we, input bit re, input int addr, input logic [DW-1:0] wd,
                     input bit wt, input bit rt, input string dtag);
    chk(busy === 1'b1, {cur_tag, " R13 busy"}, DW'(busy), DW'(1));
    chk(done === 1'b0, {cur_tag, " R13 done low"}, DW'(done), DW'(0));
    chk(ram_we === we, {cur_tag, " R3 we"}, DW'(ram_we), DW'(we));
    chk(ram_re === re, {cur_tag, " R3 re"}, DW'(ram_re), DW'(re));
    if (we || re) chk(ram_addr === AW'(addr), {cur_tag, " R3 R6 addr"}, DW'(ram_addr), DW'(addr));
    if (we) chk(ram_wdata === wd, {cur_tag, " ", dtag, " wdata"}, ram_wdata, wd);
    chk(wtrig === wt, {cur_tag, " R11 wtrig"}, DW'(wtrig), DW'(wt));
    chk(rtrig === rt, {cur_tag, " R12 rtrig"}, DW'(rtrig), DW'(rt));
    if (ccount == poke_at) begin
      start  = 1'b1;          // R2: must be ignored while busy
      cfg_lo = 8'd99;
    end else begin
      start = 1'b0;
    end
    ccount++;
    @(negedge clk);
  endtask

  task automatic run_case(input string tag, input int lo, input int hi, input int stp,
                          input logic [HW-1:0] mh, input logic [HW-1:0] ml,
                          input int wta, input int rta, input int poke);
    int addrs[$];
    int n, step_e, f_addr;
    logic [DW-1:0] base, d, act, f_exp, f_act;
    logic [DW-1:0] mask;
    logic [1:0] f_half;
    bit stop, pend;
    cur_tag = tag;
    mask = {mh, ml};
    step_e = (stp == 0) ? 1 : stp;
    for (int a = lo; a <= hi; a += step_e) addrs.push_back(a);
    n = addrs.size();
    @(negedge clk);
    cfg_lo = AW'(lo); cfg_hi = AW'(hi); cfg_step = AW'(stp);
    cfg_mask_hi = mh; cfg_mask_lo = ml;
    cfg_wtrig_addr = AW'(wta); cfg_rtrig_addr = AW'(rta);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ccount = 0;
    poke_at = poke;
    if (lo > hi) begin
      chk(done === 1'b1, {tag, " R7 done"}, DW'(done), DW'(1));
      chk(busy === 1'b0, {tag, " R7 busy"}, DW'(busy), DW'(0));
      chk(fail === 1'b0, {tag, " R7 fail"}, DW'(fail), DW'(0));
      chk((ram_we | ram_re) === 1'b0, {tag, " R7 access"}, DW'(ram_we | ram_re), DW'(0));
      @(negedge clk);
      chk(done === 1'b1, {tag, " R7 R13 done held"}, DW'(done), DW'(1));
      return;
    end
    base = DW'(1);
    stop = 0; pend = 0;
    f_addr = 0; f_exp = '0; f_act = '0; f_half = '0;
    for (int p = 0; p < 2 * DW && !stop; p++) begin
      cyc(0, 0, 0, '0, lo == wta, 0, "R3");
      d = base;
      for (int i = 0; i < n; i++) begin
        cyc(1, 0, addrs[i], d, (i + 1 < n) && (addrs[i+1] == wta), 0, (i == 0) ? "R5" : "R4");
        d = rotl(d);
      end
      cyc(0, 0, 0, '0, 0, lo == rta, "R3");
      d = base;
      for (int i = 0; i < n; i++) begin
        cyc(0, 1, addrs[i], '0, 0, (i + 1 < n) && (addrs[i+1] == rta), "R3");
        if (pend) begin stop = 1; break; end
        act = fault(addrs[i], d);
        if (((act ^ d) & mask) != '0) begin
          pend   = 1;
          f_addr = addrs[i];
          f_exp  = d;
          f_act  = act;
          f_half = {|((act[DW-1:HW] ^ d[DW-1:HW]) & mh), |((act[HW-1:0] ^ d[HW-1:0]) & ml)};
        end
        d = rotl(d);
      end
      if (!stop) begin
        cyc(0, 0, 0, '0, 0, 0, "R3");
        if (pend) stop = 1;
      end
      base = (p == DW - 1) ? ~DW'(1) : rotl(base);
    end
    poke_at = -1;
    chk(done === 1'b1, {tag, " R13 done"}, DW'(done), DW'(1));
    chk(busy === 1'b0, {tag, " R13 busy low"}, DW'(busy), DW'(0));
    chk(fail === pend, {tag, pend ? " R10 fail" : " R9 fail"}, DW'(fail), DW'(pend));
    chk((ram_we | ram_re) === 1'b0, {tag, " R10 quiet"}, DW'(ram_we | ram_re), DW'(0));
    if (pend) begin
      chk(fail_addr === AW'(f_addr), {tag, " R10 fail_addr"}, DW'(fail_addr), DW'(f_addr));
      chk(fail_half === f_half, {tag, " R10 fail_half"}, DW'(fail_half), DW'(f_half));
      chk(fail_exp === f_exp, {tag, " R10 fail_exp"}, fail_exp, f_exp);
      chk(fail_act === f_act, {tag, " R8 fail_act"}, fail_act, f_act);
    end
    @(negedge clk);
    chk(done === 1'b1, {tag, " R13 done held"}, DW'(done), DW'(1));
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL R13 watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({busy, done, fail, ram_we, ram_re, wtrig, rtrig} === 7'b0, "R1 reset outputs",
        DW'({busy, done, fail, ram_we, ram_re, wtrig, rtrig}), DW'(0));

    run_case("R2 basic", 0, 5, 1, '1, '1, 2, 0, 7);
    run_case("R6 step3", 10, 30, 3, '1, '1, 10, 28, -1);
    run_case("R6 step0 top", 250, 255, 0, '1, '1, 255, 251, -1);
    run_case("R7 empty", 7, 3, 1, '1, '1, 0, 0, -1);
    run_case("single", 42, 42, 1, '1, '1, 42, 42, -1);

    stuck_en = 1; stuck_addr = 3; stuck_bit = 40; stuck_val = 1'b0;
    run_case("R10 upper", 0, 7, 1, '1, '1, 1, 2, -1);
    run_case("R9 masked", 0, 7, 1, ~(HW'(1) << 4), '1, 1, 2, -1);
    stuck_addr = 0; stuck_bit = 5; stuck_val = 1'b1;
    run_case("R10 lower", 0, 7, 1, '1, '1, 0, 0, -1);
    stuck_en = 0;

    run_case("wide", 0, 63, 1, '1, '1, 63, 1, -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule